// File: doc/BRIEF.md
# Strided Transfer Address Generator

This block sequences the addresses for one side of a DMA transfer, either the read side or the write side. A load strobe captures a 32-bit side control word, a 32-bit base address, a 4-bit upper address extension, a 22-bit total byte count and a stride-enable flag. The block then presents one address per beat, along with that beat's size in bytes. Each time the consumer asserts advance, the block steps to the next beat. When the byte count has been used up, it raises done.

The side control word holds four fields. Bits 31:30 give the beat size code. Bits 29:28 give the movement mode. Bits 27:14 give the block length in bytes, and bits 13:0 give the stride in bytes. Without stride mode, the address runs linearly according to the movement mode. With stride mode, the address moves within a block as the mode dictates. Once the block length has been issued, the next block starts at the previous block's start plus the stride. The extension nibble sits above the 32-bit address and never receives a carry from it.

Top module: `stride_addr_gen`

## Requirements
- R1: After reset, done is 1 and beat_bytes is 0.
- R2: A size code of 0, 1, 2 or 3 (side word bits 31:30) gives a beat of 1, 2, 4 or 8 bytes.
- R3: Movement mode (side word bits 29:28) is 0 for increment by the beat size, 1 for decrement by the beat size, or 2 for a fixed address.
- R4: Mode 3 (burst) steps the address the same way as mode 0, and burst_ok is 1 while this mode is loaded; in the other modes burst_ok is 0.
- R5: When stride_en is 1 and the block length (bits 27:14) is nonzero, the block ends once its issued bytes reach the block length. The next beat's address is then the block start plus the stride (bits 13:0), and that address becomes the new block start.
- R6: When stride_en is 0, the block length and stride fields have no effect, and the address moves linearly.
- R7: When fewer bytes remain than the beat size, beat_bytes shows the remaining byte count.
- R8: done is 1 exactly when the remaining count is zero. While done is 1, advance has no effect on addr, and beat_bytes is 0.
- R9: State changes only on a clock edge where advance is 1 and done is 0, or where load is 1. When load and advance are both 1, load wins and no count is consumed.
- R10: addr is the 4-bit extension placed above the 32-bit running address. When the low address wraps past all ones, the extension does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Capture the descriptor fields |
| side_word | input | 32 | Size code, movement mode, block length, stride |
| base_addr | input | 32 | Start address |
| addr_ext | input | 4 | Upper address extension |
| byte_count | input | 22 | Total bytes to transfer |
| stride_en | input | 1 | Enable block/stride addressing |
| advance | input | 1 | Consume the current beat |
| addr | output | 36 | Current beat address |
| beat_bytes | output | 4 | Bytes in the current beat (0 when done) |
| burst_ok | output | 1 | Burst movement mode loaded |
| done | output | 1 | Byte count exhausted |

## Verification
The bench targets the block boundary in both increment and decrement stride patterns. A design that counted issued bytes wrongly, or that measured the next block from the current address instead of the block start, would produce shifted block addresses. It also issues a byte count smaller than one beat and one that ends on a partial beat. A design that did not clamp the final beat would report 8 there instead of the leftover bytes. Further cases cover a low address wrapping past all ones, where a careless carry would corrupt the extension nibble. Finally, it asserts load and advance together, where wrong priority would show up as one beat too few before done.

// File: rtl/sag_pkg.sv
package sag_pkg;

    localparam int SIZE_CODE_W = 2;
    localparam int MODE_W      = 2;
    localparam int BEAT_W      = 4;

    typedef enum logic [MODE_W-1:0] {
        MV_INC   = 2'd0,
        MV_DEC   = 2'd1,
        MV_FIX   = 2'd2,
        MV_BURST = 2'd3
    } move_e;

    function automatic logic [BEAT_W-1:0] code_to_bytes(input logic [SIZE_CODE_W-1:0] code);
        return BEAT_W'(1) << code;
    endfunction

endpackage

// File: rtl/sag_beat_sizer.sv
module sag_beat_sizer
    import sag_pkg::*;
#(
    parameter int CNT_W = 22
) (
    input  logic [SIZE_CODE_W-1:0] size_code,
    input  logic [CNT_W-1:0]       remaining,
    output logic [BEAT_W-1:0]      full_bytes,
    output logic [BEAT_W-1:0]      beat_bytes
);
    always_comb begin
        full_bytes = code_to_bytes(size_code);
        if (remaining < CNT_W'(full_bytes)) begin
            beat_bytes = remaining[BEAT_W-1:0];
        end else begin
            beat_bytes = full_bytes;
        end
    end
endmodule

// File: rtl/sag_addr_step.sv
module sag_addr_step
    import sag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int FLD_W  = 14
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] blk_start,
    input  logic [FLD_W-1:0]  blk_used,
    input  logic [BEAT_W-1:0] full_bytes,
    input  move_e             mode,
    input  logic [FLD_W-1:0]  blk_len,
    input  logic [FLD_W-1:0]  stride,
    input  logic              strided,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic [ADDR_W-1:0] nxt_start,
    output logic [FLD_W-1:0]  nxt_used
);
    localparam int SUM_W = FLD_W + 1;

    logic [ADDR_W-1:0] lin_addr;
    logic [SUM_W-1:0]  used_sum;
    logic              blk_end;

    always_comb begin
        unique case (mode)
            MV_INC, MV_BURST: lin_addr = cur_addr + ADDR_W'(full_bytes);
            MV_DEC:           lin_addr = cur_addr - ADDR_W'(full_bytes);
            default:          lin_addr = cur_addr;
        endcase
    end

    always_comb begin
        used_sum = SUM_W'(blk_used) + SUM_W'(full_bytes);
        blk_end  = strided && (used_sum >= SUM_W'(blk_len));
        if (blk_end) begin
            nxt_start = blk_start + ADDR_W'(stride);
            nxt_addr  = blk_start + ADDR_W'(stride);
            nxt_used  = '0;
        end else begin
            nxt_start = blk_start;
            nxt_addr  = lin_addr;
            nxt_used  = strided ? used_sum[FLD_W-1:0] : blk_used;
        end
    end
endmodule

// File: rtl/stride_addr_gen.sv
module stride_addr_gen
    import sag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int EXT_W  = 4,
    parameter int CNT_W  = 22,
    parameter int FLD_W  = 14,
    localparam int SIDE_W = 2 * FLD_W + MODE_W + SIZE_CODE_W,
    localparam int OUT_W  = ADDR_W + EXT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SIDE_W-1:0] side_word,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [EXT_W-1:0]  addr_ext,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic              stride_en,
    input  logic              advance,
    output logic [OUT_W-1:0]  addr,
    output logic [BEAT_W-1:0] beat_bytes,
    output logic              burst_ok,
    output logic              done
);
    localparam int STR_LO  = 0;
    localparam int BLK_LO  = FLD_W;
    localparam int MODE_LO = 2 * FLD_W;
    localparam int SIZE_LO = MODE_LO + MODE_W;

    typedef struct packed {
        logic [ADDR_W-1:0]      cur_addr;
        logic [ADDR_W-1:0]      blk_start;
        logic [FLD_W-1:0]       blk_used;
        logic [CNT_W-1:0]       remaining;
        logic [EXT_W-1:0]       ext;
        logic [SIZE_CODE_W-1:0] size_code;
        move_e                  mode;
        logic [FLD_W-1:0]       blk_len;
        logic [FLD_W-1:0]       stride;
        logic                   strided;
    } sag_state_t;

    sag_state_t st_d, st_q;

    logic [BEAT_W-1:0] full_bytes;
    logic [BEAT_W-1:0] cur_beat;
    logic [ADDR_W-1:0] step_addr;
    logic [ADDR_W-1:0] step_start;
    logic [FLD_W-1:0]  step_used;
    logic              empty;

    sag_beat_sizer #(.CNT_W(CNT_W)) u_sizer (
        .size_code  (st_q.size_code),
        .remaining  (st_q.remaining),
        .full_bytes (full_bytes),
        .beat_bytes (cur_beat)
    );

    sag_addr_step #(.ADDR_W(ADDR_W), .FLD_W(FLD_W)) u_step (
        .cur_addr   (st_q.cur_addr),
        .blk_start  (st_q.blk_start),
        .blk_used   (st_q.blk_used),
        .full_bytes (full_bytes),
        .mode       (st_q.mode),
        .blk_len    (st_q.blk_len),
        .stride     (st_q.stride),
        .strided    (st_q.strided),
        .nxt_addr   (step_addr),
        .nxt_start  (step_start),
        .nxt_used   (step_used)
    );

    assign empty = (st_q.remaining == '0);

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cur_addr  = base_addr;
            st_d.blk_start = base_addr;
            st_d.blk_used  = '0;
            st_d.remaining = byte_count;
            st_d.ext       = addr_ext;
            st_d.size_code = side_word[SIZE_LO +: SIZE_CODE_W];
            st_d.mode      = move_e'(side_word[MODE_LO +: MODE_W]);
            st_d.blk_len   = side_word[BLK_LO +: FLD_W];
            st_d.stride    = side_word[STR_LO +: FLD_W];
            st_d.strided   = stride_en && (side_word[BLK_LO +: FLD_W] != '0);
        end else if (advance && !empty) begin
            st_d.remaining = st_q.remaining - CNT_W'(cur_beat);
            st_d.cur_addr  = step_addr;
            st_d.blk_start = step_start;
            st_d.blk_used  = step_used;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cur_addr: '0, blk_start: '0, blk_used: '0, remaining: '0,
                      ext: '0, size_code: '0, mode: MV_INC, blk_len: '0,
                      stride: '0, strided: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign addr       = {st_q.ext, st_q.cur_addr};
    assign beat_bytes = empty ? '0 : cur_beat;
    assign burst_ok   = (st_q.mode == MV_BURST);
    assign done       = empty;

endmodule

// File: rtl/sag_checker.sv
module sag_checker #(
    parameter int OUT_W  = 36,
    parameter int EXT_W  = 4,
    parameter int BEAT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load,
    input logic              advance,
    input logic [OUT_W-1:0]  addr,
    input logic [BEAT_W-1:0] beat_bytes,
    input logic              done
);
    a_r8_done_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (beat_bytes == '0));

    a_r7_beat_range: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (beat_bytes != '0) && (beat_bytes <= BEAT_W'(8)));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !advance) |=> $stable(addr) && $stable(done));

    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done && $stable(addr));

    a_r10_ext_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(addr[OUT_W-1:OUT_W-EXT_W]));
endmodule

bind stride_addr_gen sag_checker #(.OUT_W(OUT_W), .EXT_W(EXT_W), .BEAT_W(sag_pkg::BEAT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .advance    (advance),
    .addr       (addr),
    .beat_bytes (beat_bytes),
    .done       (done)
);

// File: tb/sim_stride_addr_gen.sv
`timescale 1ns/1ps
module sim_stride_addr_gen;
    localparam int NV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [31:0] side_word = '0;
    logic [31:0] base_addr = '0;
    logic [3:0]  addr_ext = '0;
    logic [21:0] byte_count = '0;
    logic        stride_en = 1'b0;
    logic        advance = 1'b0;
    logic [35:0] addr;
    logic [3:0]  beat_bytes;
    logic        burst_ok;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    stride_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .load(load), .side_word(side_word),
        .base_addr(base_addr), .addr_ext(addr_ext), .byte_count(byte_count),
        .stride_en(stride_en), .advance(advance), .addr(addr),
        .beat_bytes(beat_bytes), .burst_ok(burst_ok), .done(done)
    );

    // side word: {size[1:0], mode[1:0], block[13:0], stride[13:0]}
    localparam logic [31:0] V_SIDE [NV] = '{
        {2'd2, 2'd0, 14'd0, 14'd0},
        {2'd1, 2'd1, 14'd0, 14'd0},
        {2'd0, 2'd2, 14'd0, 14'd0},
        {2'd3, 2'd3, 14'd0, 14'd0},
        {2'd2, 2'd0, 14'd8, 14'h40},
        {2'd1, 2'd1, 14'd4, 14'h20},
        {2'd3, 2'd0, 14'd0, 14'd0},
        {2'd2, 2'd0, 14'd8, 14'h40}
    };
    localparam logic [31:0] V_BASE [NV] = '{32'h1000, 32'h200, 32'h55, 32'h0,
                                            32'h100, 32'h80, 32'h10, 32'h100};
    localparam logic [3:0]  V_EXT  [NV] = '{4'h3, 4'h0, 4'h1, 4'h0, 4'h0, 4'h0, 4'h7, 4'h0};
    localparam logic [21:0] V_CNT  [NV] = '{22'd16, 22'd6, 22'd3, 22'd20, 22'd24, 22'd8, 22'd5, 22'd12};
    localparam logic        V_SEN  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
    localparam int          V_N    [NV] = '{4, 3, 3, 3, 6, 4, 1, 3};
    localparam logic        V_BUR  [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
    localparam logic [191:0] V_ADDR [NV] = '{
        {32'h0, 32'h0, 32'h100C, 32'h1008, 32'h1004, 32'h1000},
        {32'h0, 32'h0, 32'h0, 32'h1FC, 32'h1FE, 32'h200},
        {32'h0, 32'h0, 32'h0, 32'h55, 32'h55, 32'h55},
        {32'h0, 32'h0, 32'h0, 32'h10, 32'h8, 32'h0},
        {32'h184, 32'h180, 32'h144, 32'h140, 32'h104, 32'h100},
        {32'h0, 32'h0, 32'h9E, 32'hA0, 32'h7E, 32'h80},
        {32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h10},
        {32'h0, 32'h0, 32'h0, 32'h108, 32'h104, 32'h100}
    };
    localparam logic [23:0] V_SZ [NV] = '{
        {4'd0, 4'd0, 4'd4, 4'd4, 4'd4, 4'd4},
        {4'd0, 4'd0, 4'd0, 4'd2, 4'd2, 4'd2},
        {4'd0, 4'd0, 4'd0, 4'd1, 4'd1, 4'd1},
        {4'd0, 4'd0, 4'd0, 4'd4, 4'd8, 4'd8},
        {4'd4, 4'd4, 4'd4, 4'd4, 4'd4, 4'd4},
        {4'd0, 4'd0, 4'd2, 4'd2, 4'd2, 4'd2},
        {4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd5},
        {4'd0, 4'd0, 4'd0, 4'd4, 4'd4, 4'd4}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_load(input logic [31:0] sw, input logic [31:0] b, input logic [3:0] e,
                           input logic [21:0] c, input logic se, input logic adv);
        side_word = sw; base_addr = b; addr_ext = e; byte_count = c; stride_en = se;
        load = 1'b1; advance = adv;
        @(negedge clk);
        load = 1'b0; advance = 1'b0;
    endtask

    task automatic step();
        advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 done after reset", 64'(done), 64'd1);
        check("R1 beat after reset", 64'(beat_bytes), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5 R6 R7 R8: vector table
        for (int v = 0; v < NV; v++) begin
            do_load(V_SIDE[v], V_BASE[v], V_EXT[v], V_CNT[v], V_SEN[v], 1'b0);
            check($sformatf("R4 burst_ok v%0d", v), 64'(burst_ok), 64'(V_BUR[v]));
            check($sformatf("R10 ext v%0d", v), 64'(addr[35:32]), 64'(V_EXT[v]));
            for (int b = 0; b < V_N[v]; b++) begin
                check($sformatf("R3/R5/R6 addr v%0d b%0d", v, b), 64'(addr[31:0]), 64'(V_ADDR[v][b*32 +: 32]));
                check($sformatf("R2/R7 size v%0d b%0d", v, b), 64'(beat_bytes), 64'(V_SZ[v][b*4 +: 4]));
                check($sformatf("R8 not done v%0d b%0d", v, b), 64'(done), 64'd0);
                step();
            end
            check($sformatf("R8 done at end v%0d", v), 64'(done), 64'd1);
        end

        // R8: advance while done is ignored
        begin
            logic [35:0] held;
            held = addr;
            step(); step();
            check("R8 addr frozen when done", 64'(addr), 64'(held));
            check("R8 still done", 64'(done), 64'd1);
            check("R8 no beat when done", 64'(beat_bytes), 64'd0);
        end

        // R10: low address wrap leaves extension intact
        do_load({2'd2, 2'd0, 14'd0, 14'd0}, 32'hFFFF_FFFC, 4'hA, 22'd8, 1'b0, 1'b0);
        check("R10 before wrap", 64'(addr), 64'h0000_000A_FFFF_FFFC);
        step();
        check("R10 after wrap", 64'(addr), 64'h0000_000A_0000_0000);

        // R9: idle cycles hold state
        do_load({2'd2, 2'd0, 14'd0, 14'd0}, 32'h1000, 4'h0, 22'd16, 1'b0, 1'b0);
        step();
        repeat (3) @(negedge clk);
        check("R9 hold without advance", 64'(addr), 64'h1004);
        // R9: load wins over advance
        do_load({2'd2, 2'd0, 14'd0, 14'd0}, 32'h2000, 4'h0, 22'd8, 1'b0, 1'b1);
        check("R9 load priority addr", 64'(addr), 64'h2000);
        step();
        check("R9 load priority one beat left", 64'(done), 64'd0);
        step();
        check("R9 load priority done after two", 64'(done), 64'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule